// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Line Status

This block turns an asynchronous serial line into bytes. It uses a receive clock enable that pulses sixteen times per bit period. It follows the character format set by its format inputs: five to eight data bits, optional parity checking (odd, even, or a fixed parity value), and one or two stop bits. Each received character goes into a one-entry holding register, and a status byte records what happened to it.

Software-facing logic sees two registers as plain ports: the received byte and a status byte. It acknowledges them with single-cycle read strobes. Reading the byte clears data ready. Reading the status clears the four error flags. An error flag stays set across several characters until the status is read.

A line held at space for longer than one whole character produces a single all-zero character flagged as a break. The receiver then stays silent until the line returns to mark.

Top module: `async_rx_lsr`

## Requirements
- R1: A bit period is 16 pulses of `tick16`. An idle receiver that samples a 0 on a tick starts a frame. The start bit is sampled again 8 ticks later, and if the line is 1 by then the frame is dropped and nothing is stored.
- R2: Data bits are sampled every 16 ticks after the start-bit sample, least significant bit first. The count is 5 + `cfg_wlen` (0 to 3 gives 5 to 8 bits). `rx_data` holds the character right-justified, with unused upper bits 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_stick` at 0, `cfg_par_even` = 1 expects an even count of ones over data plus parity, and 0 expects an odd count. With `cfg_par_stick` at 1, the expected parity bit is the inverse of `cfg_par_even`. A mismatch sets status bit 2.
- R4: Only the first stop bit is sampled. If it is 0, status bit 3 is set. A character with a 0 stop sample is stored once the line returns to 1, or when a break is detected. `cfg_stop2` never affects this check.
- R5: If the line is low for 16 × (1 + data bits + parity bit + stop bits) consecutive ticks, a break is detected. Stop bits count as 2 when `cfg_stop2` is 1. One character 0x00 is stored with status bits 4 and 3 set and bit 2 clear. No further start is accepted until the line reads 1.
- R6: Storing a character sets status bit 0. `rx_data` changes only when a character is stored.
- R7: If a character is stored while bit 0 is set and `rd_data` is not active in that cycle, status bit 1 is set. The older byte is replaced.
- R8: `rd_status` clears status bits 4..1 and `rd_data` clears bit 0, both on the next clock edge. A character stored in the same cycle takes priority. Bits 7..5 always read 0.
- R9: After reset, `status` is 0x00 and `rx_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial input, 1 = mark/idle |
| tick16 | input | 1 | Clock enable, 16 pulses per bit period |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity select (inverted value when fixed) |
| cfg_par_stick | input | 1 | Fixed parity value mode |
| cfg_stop2 | input | 1 | Two stop bits (lengthens the break window only) |
| rd_data | input | 1 | Read strobe for the received byte |
| rd_status | input | 1 | Read strobe for the status byte |
| rx_data | output | 8 | Last stored character |
| status | output | 8 | {3'b0, break, framing, parity, overrun, data ready} |

## Verification
The assertions check the status register on every cycle. Storing a character raises data ready. A store onto unread data raises overrun. The read strobes clear their flags. The held byte never changes without a store. A break character is always zero with framing set. Stores only follow a tick. Sampling points, parity evaluation in each mode, glitch rejection, and break length under one and two stop bits all depend on whole serial waveforms. Only the bench's frames can show these, through the byte and status read back afterwards.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_STOPLOW,
    RX_BRKWAIT
  } rx_state_e;

  typedef struct packed {
    logic bi;
    logic fe;
    logic pe;
    logic oe;
    logic dr;
  } lsr_t;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/arx_low_timer.sv
// Counts consecutive low ticks and flags a full-frame low run (R5).
module arx_low_timer #(
  parameter int OVS   = 16,
  parameter int LOW_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_s,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_stop2,
  output logic       brk_hit
);
  logic [LOW_W-1:0] cnt, cnt_n;
  logic [3:0]       frame_bits;
  logic [LOW_W-1:0] frame_ticks;

  // start + 5 base data + 1 stop = 7, plus the variable parts
  assign frame_bits  = 4'd7 + {2'b00, cfg_wlen} + {3'b000, cfg_par_en} + {3'b000, cfg_stop2};
  assign frame_ticks = LOW_W'(frame_bits) * LOW_W'(OVS);

  always_comb begin
    cnt_n = cnt;
    if (tick) begin
      if (line_s)          cnt_n = '0;
      else if (cnt != '1)  cnt_n = cnt + LOW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign brk_hit = (cnt >= frame_ticks);
endmodule

// File: rtl/arx_frame_fsm.sv
module arx_frame_fsm
  import arx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_s,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              brk_hit,
  output logic              char_valid,
  output logic [BYTE_W-1:0] char_data,
  output logic              char_pe,
  output logic              char_fe,
  output logic              char_bi
);
  localparam int TCNT_W = $clog2(OVS);
  localparam logic [TCNT_W-1:0] T_FULL = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] T_HALF = TCNT_W'(OVS / 2 - 1);

  rx_state_e         state, state_n;
  logic [TCNT_W-1:0] tcnt, tcnt_n;
  logic [2:0]        bidx, bidx_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              par_q, par_n;
  logic              cv_n, cpe_n, cfe_n, cbi_n;
  logic [BYTE_W-1:0] cd_n;

  logic [2:0]        last_idx;
  logic [BYTE_W-1:0] data_just;
  logic              perr;

  assign last_idx  = 3'd4 + {1'b0, cfg_wlen};
  // bits enter at the MSB; shift down by 8 - width (R2)
  assign data_just = sh >> (2'd3 - cfg_wlen);
  // R3: normal parity compares the total count, fixed parity the bit itself
  assign perr = cfg_par_en &
                (cfg_par_stick ? (par_q ^ ~cfg_par_even)
                               : (^data_just ^ par_q ^ ~cfg_par_even));

  always_comb begin
    state_n = state;
    tcnt_n  = tcnt;
    bidx_n  = bidx;
    sh_n    = sh;
    par_n   = par_q;
    cv_n    = 1'b0;
    cd_n    = char_data;
    cpe_n   = char_pe;
    cfe_n   = char_fe;
    cbi_n   = char_bi;
    if (tick) begin
      unique case (state)
        RX_IDLE: begin
          if (!line_s) begin
            state_n = RX_START;
            tcnt_n  = '0;
          end
        end
        RX_START: begin  // R1: mid-start recheck rejects glitches
          if (tcnt == T_HALF) begin
            tcnt_n  = '0;
            bidx_n  = '0;
            state_n = line_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_n = tcnt + TCNT_W'(1);
          end
        end
        RX_DATA: begin
          if (tcnt == T_FULL) begin
            tcnt_n = '0;
            sh_n   = {line_s, sh[BYTE_W-1:1]};
            if (bidx == last_idx) state_n = cfg_par_en ? RX_PAR : RX_STOP;
            else                  bidx_n  = bidx + 3'd1;
          end else begin
            tcnt_n = tcnt + TCNT_W'(1);
          end
        end
        RX_PAR: begin
          if (tcnt == T_FULL) begin
            tcnt_n  = '0;
            par_n   = line_s;
            state_n = RX_STOP;
          end else begin
            tcnt_n = tcnt + TCNT_W'(1);
          end
        end
        RX_STOP: begin  // R4: only this first stop sample is judged
          if (tcnt == T_FULL) begin
            tcnt_n = '0;
            if (line_s) begin
              cv_n    = 1'b1;
              cd_n    = data_just;
              cpe_n   = perr;
              cfe_n   = 1'b0;
              cbi_n   = 1'b0;
              state_n = RX_IDLE;
            end else begin
              state_n = RX_STOPLOW;
            end
          end else begin
            tcnt_n = tcnt + TCNT_W'(1);
          end
        end
        RX_STOPLOW: begin
          if (line_s) begin
            cv_n    = 1'b1;
            cd_n    = data_just;
            cpe_n   = perr;
            cfe_n   = 1'b1;
            cbi_n   = 1'b0;
            state_n = RX_IDLE;
          end else if (brk_hit) begin  // R5
            cv_n    = 1'b1;
            cd_n    = '0;
            cpe_n   = 1'b0;
            cfe_n   = 1'b1;
            cbi_n   = 1'b1;
            state_n = RX_BRKWAIT;
          end
        end
        RX_BRKWAIT: begin
          if (line_s) state_n = RX_IDLE;
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      sh         <= '0;
      par_q      <= 1'b0;
      char_valid <= 1'b0;
      char_data  <= '0;
      char_pe    <= 1'b0;
      char_fe    <= 1'b0;
      char_bi    <= 1'b0;
    end else begin
      state      <= state_n;
      tcnt       <= tcnt_n;
      bidx       <= bidx_n;
      sh         <= sh_n;
      par_q      <= par_n;
      char_valid <= cv_n;
      char_data  <= cd_n;
      char_pe    <= cpe_n;
      char_fe    <= cfe_n;
      char_bi    <= cbi_n;
    end
  end
endmodule

// File: rtl/arx_status.sv
module arx_status
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [BYTE_W-1:0] char_data,
  input  logic              char_pe,
  input  logic              char_fe,
  input  logic              char_bi,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [BYTE_W-1:0] rx_data,
  output logic [7:0]        status
);
  lsr_t              st, st_n;
  logic [BYTE_W-1:0] data_q, data_n;

  always_comb begin
    data_n = char_valid ? char_data : data_q;
    // R8: a read clears, a new character in the same cycle wins
    st_n.dr = (st.dr & ~rd_data) | char_valid;
    st_n.oe = (st.oe & ~rd_status) | (char_valid & st.dr & ~rd_data);  // R7
    st_n.pe = (st.pe & ~rd_status) | (char_valid & char_pe);
    st_n.fe = (st.fe & ~rd_status) | (char_valid & char_fe);
    st_n.bi = (st.bi & ~rd_status) | (char_valid & char_bi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin  // R9
      st     <= '0;
      data_q <= '0;
    end else begin
      st     <= st_n;
      data_q <= data_n;
    end
  end

  assign rx_data = data_q;
  assign status  = {3'b000, st};
endmodule

// File: rtl/async_rx_lsr.sv
module async_rx_lsr #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       cfg_stop2,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_data,
  output logic [7:0] status
);
  localparam int MAX_BITS = 12;
  localparam int LOW_W    = $clog2(MAX_BITS * OVS + 1);

  logic [1:0] rst_pipe;
  logic       rst_i_n;
  logic       line_s;
  logic       brk_hit;
  logic       char_valid;
  logic [7:0] char_data;
  logic       char_pe, char_fe, char_bi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(rx_line), .q(line_s)
  );

  arx_low_timer #(.OVS(OVS), .LOW_W(LOW_W)) u_low (
    .clk(clk), .rst_n(rst_i_n), .tick(tick16), .line_s(line_s),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2),
    .brk_hit(brk_hit)
  );

  arx_frame_fsm #(.OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .tick(tick16), .line_s(line_s),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .brk_hit(brk_hit),
    .char_valid(char_valid), .char_data(char_data),
    .char_pe(char_pe), .char_fe(char_fe), .char_bi(char_bi)
  );

  arx_status u_stat (
    .clk(clk), .rst_n(rst_i_n), .char_valid(char_valid), .char_data(char_data),
    .char_pe(char_pe), .char_fe(char_fe), .char_bi(char_bi),
    .rd_data(rd_data), .rd_status(rd_status),
    .rx_data(rx_data), .status(status)
  );
endmodule

// File: rtl/arx_checker.sv
module arx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       rd_data,
  input logic       rd_status,
  input logic [7:0] rx_data,
  input logic [7:0] status,
  input logic       char_valid,
  input logic [7:0] char_data,
  input logic       char_pe,
  input logic       char_fe,
  input logic       char_bi
);
  p_store_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> $past(tick16));

  p_dr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> status[0]);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |=> $stable(rx_data));

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && status[0] && !rd_data) |=> status[1]);

  p_rd_data_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !char_valid) |=> !status[0]);

  p_rd_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !char_valid) |=> (status[4:1] == 4'b0000));

  p_break_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_bi) |-> (char_data == 8'h00 && char_fe && !char_pe));
endmodule

bind async_rx_lsr arx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rd_data(rd_data),
  .rd_status(rd_status), .rx_data(rx_data), .status(status),
  .char_valid(char_valid), .char_data(char_data),
  .char_pe(char_pe), .char_fe(char_fe), .char_bi(char_bi)
);

// File: tb/sim_async_rx_lsr.sv
module sim_async_rx_lsr;
  localparam int TDIV = 4;  // clocks per tick16

  logic       clk;
  logic       rst_n;
  logic       rx_line;
  logic       tick16;
  logic [1:0] cfg_wlen;
  logic       cfg_par_en, cfg_par_even, cfg_par_stick, cfg_stop2;
  logic       rd_data, rd_status;
  logic [7:0] rx_data, status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int tdiv_cnt = 0;

  async_rx_lsr u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_stop2(cfg_stop2),
    .rd_data(rd_data), .rd_status(rd_status),
    .rx_data(rx_data), .status(status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick16   <= (tdiv_cnt == TDIV - 1);
  end

  typedef struct packed {
    logic [1:0] wlen;
    logic       pen;
    logic       peven;
    logic       pstick;
    logic [7:0] data;
    logic       badpar;
    logic       stopv;
    logic [7:0] exp_data;
    logic [4:0] exp_st;   // {bi, fe, pe, oe, dr}
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 5'h01}, // R2 8 bits
    '{2'd3, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 5'h01}, // R3 even ok
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 1'b1, 8'h81, 5'h05}, // R3 odd bad
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'h15, 1'b0, 1'b1, 8'h15, 5'h01}, // R2 5 bits
    '{2'd1, 1'b1, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b1, 8'h2A, 5'h05}, // R3 6 bits bad
    '{2'd2, 1'b1, 1'b0, 1'b1, 8'h40, 1'b0, 1'b1, 8'h40, 5'h01}, // R3 fixed 1 ok
    '{2'd2, 1'b1, 1'b1, 1'b1, 8'h7F, 1'b1, 1'b1, 8'h7F, 5'h05}, // R3 fixed 0 bad
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h5A, 5'h09}, // R4 framing
    '{2'd3, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 8'hFF, 5'h0D}, // R3 R4 both
    '{2'd0, 1'b1, 1'b1, 1'b0, 8'hE3, 1'b0, 1'b1, 8'h03, 5'h01}  // R2 justify
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int nticks);
    rx_line = v;
    repeat (nticks * TDIV) @(negedge clk);
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] wl,
                                   input logic even, input logic stick);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 5 + int'(wl); i++) x ^= d[i];
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction

  task automatic send(input logic [7:0] d, input logic badpar, input logic stopv);
    hold(1'b0, 16);
    for (int i = 0; i < 5 + int'(cfg_wlen); i++) hold(d[i], 16);
    if (cfg_par_en)
      hold(par_bit(d, cfg_wlen, cfg_par_even, cfg_par_stick) ^ badpar, 16);
    hold(stopv, 16);
    if (cfg_stop2) hold(1'b1, 16);
    hold(1'b1, 32);
  endtask

  task automatic pulse_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_status();
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
  endtask

  task automatic set_fmt(input logic [1:0] wl, input logic pen, input logic pev,
                         input logic pst, input logic s2);
    cfg_wlen = wl; cfg_par_en = pen; cfg_par_even = pev;
    cfg_par_stick = pst; cfg_stop2 = s2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; rd_data = 1'b0; rd_status = 1'b0;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    // R9: reset values
    chk("R9 status after reset", status, 8'h00);
    chk("R9 data after reset", rx_data, 8'h00);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // table walk: R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      set_fmt(VECS[v].wlen, VECS[v].pen, VECS[v].peven, VECS[v].pstick, 1'b0);
      send(VECS[v].data, VECS[v].badpar, VECS[v].stopv);
      chk($sformatf("R2 R3 R6 row %0d data", v), rx_data, VECS[v].exp_data);
      chk($sformatf("R3 R4 R6 row %0d status", v), status, {3'b000, VECS[v].exp_st});
      pulse_data();
      pulse_status();
    end

    // R1: short low pulse is not a start bit
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    hold(1'b0, 4);
    hold(1'b1, 40);
    chk("R1 glitch rejected", status, 8'h00);
    send(8'h96, 1'b0, 1'b1);
    chk("R1 frame after glitch data", rx_data, 8'h96);
    chk("R1 frame after glitch status", status, 8'h01);
    pulse_data();

    // R7: two characters without reading
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    chk("R7 overrun status", status, 8'h03);
    chk("R7 newer byte kept", rx_data, 8'h22);
    pulse_status();
    chk("R8 status read keeps data ready", status, 8'h01);
    pulse_data();
    chk("R8 data read clears data ready", status, 8'h00);

    // R5: long low line, one break character only
    hold(1'b0, 16 * 30);
    hold(1'b1, 64);
    chk("R5 break data", rx_data, 8'h00);
    chk("R5 break status single char", status, 8'h19);
    pulse_data();
    pulse_status();
    send(8'hC3, 1'b0, 1'b1);
    chk("R5 recovery after break data", rx_data, 8'hC3);
    chk("R5 recovery after break status", status, 8'h01);
    pulse_data();

    // R5 R4: two stop bits lengthen the break window to 11 bits
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    hold(1'b0, 168);
    hold(1'b1, 64);
    chk("R5 stop2 no break status", status, 8'h09);
    chk("R5 stop2 no break data", rx_data, 8'h00);
    pulse_data();
    pulse_status();
    send(8'h5A, 1'b0, 1'b1);
    chk("R4 two stop bits clean status", status, 8'h01);
    chk("R4 two stop bits data", rx_data, 8'h5A);
    pulse_data();

    finish_run();
  end
endmodule